// File: doc/BRIEF.md
# Page-based address translation unit

This unit sits between a processor's memory port and the cache or memory bus below it. Every access address is split into a 4 KiB page offset, which passes through untouched, and a virtual page number. The virtual page number, together with the active context, selects one entry of a small on-chip table. The entry supplies the physical page number, a cacheable attribute and an allow flag. An allowed access goes downstream with the rebuilt physical address and the entry's cacheable attribute. The instruction/data and burst indicators are carried along unchanged. A forbidden access is swallowed and raises a sticky fault line back to the core.

Software programs the unit through a one-cycle configuration write port. An entry write selects the table slot with the index `{context, page}`. A control write loads the enable bit and the active context, so a task switch is a single control write. While the unit is disabled, the address and every access-type bit pass straight through, so no mapping is needed at boot. An identity map with per-page cacheability lets RAM be cached while a peripheral status page is not.

Top module: `page_xlate_unit`

## Requirements
- R1: With translation enabled and the selected entry allowed, the downstream address is the entry's physical page number in bits [PA_W-1:12] and the upstream address bits [11:0] unchanged.
- R2: With translation enabled, the downstream cacheable bit equals the entry's cacheable bit and ignores the upstream cacheable bit. This holds for identity-mapped pages as well.
- R3: The instruction/data indicator and the burst indicator reach the downstream side unchanged in every mode.
- R4: With translation disabled, the downstream address equals the upstream address and all three access-type bits equal their upstream values. No fault is raised, whatever the page number.
- R5: An access to an entry whose allow bit is 0 produces no downstream transfer. It sets `fault_irq` on the edge that accepts it.
- R6: With translation enabled, a virtual page number of 16 or more faults the same way as a protected entry.
- R7: The table holds 16 entries for each of 4 contexts. An entry write addresses slot `cfg_sel = {context[1:0], page[3:0]}`, and the active context chooses which 16-entry bank is used. The same virtual page can therefore map to different physical pages in different contexts.
- R8: An entry write takes effect for every access accepted on a later clock edge than the write. Rewriting a slot replaces its old mapping.
- R9: On a fault, `fault_vaddr` and `fault_ctx` capture the faulting virtual address and the active context. While `fault_irq` is high and no clear arrives, they hold, even if more faults arrive.
- R10: A `fault_clr` pulse drops `fault_irq` on the next edge. If a fault is accepted in the same cycle as the clear, `fault_irq` stays high and the new address is captured.
- R11: An accepted access appears downstream one edge later. `up_ready` equals `!dn_valid || dn_ready`. While `dn_valid` is high and `dn_ready` is low, the downstream outputs hold. Accesses leave in acceptance order.
- R12: After reset, `dn_valid` and `fault_irq` are 0, translation is disabled, the context is 0 and every table entry is protected.
- R13: A write with `cfg_ctrl` = 1 loads the enable bit from `cfg_en` and the active context from `cfg_ctx`, and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctrl | input | 1 | 1: write the control register, 0: write a table entry |
| cfg_sel | input | 6 | Table slot `{context, page}` |
| cfg_ppn | input | 20 | Physical page number for the entry |
| cfg_cache | input | 1 | Cacheable attribute for the entry |
| cfg_allow | input | 1 | 1: page accessible, 0: protected |
| cfg_en | input | 1 | Translation enable (control write) |
| cfg_ctx | input | 2 | Active context (control write) |
| up_valid | input | 1 | Upstream access valid |
| up_ready | output | 1 | Upstream access accepted |
| up_vaddr | input | 32 | Virtual address |
| up_instr | input | 1 | 1: instruction fetch, 0: data |
| up_cache | input | 1 | Upstream cacheable request |
| up_burst | input | 1 | Burst indicator |
| dn_valid | output | 1 | Downstream access valid |
| dn_ready | input | 1 | Downstream accepts |
| dn_paddr | output | 32 | Physical address |
| dn_instr | output | 1 | Instruction/data indicator |
| dn_cache | output | 1 | Cacheable attribute |
| dn_burst | output | 1 | Burst indicator |
| fault_irq | output | 1 | Sticky protection fault to the core |
| fault_vaddr | output | 32 | Captured faulting virtual address |
| fault_ctx | output | 2 | Context active at the fault |
| fault_clr | input | 1 | Clears the fault |

## Verification
The bench targets the spots where a translator tends to break.

- **Cacheable bit source.** It checks that the cacheable bit comes from the entry and not from the request, on an identity page where a wrong design would cache a device register.
- **Out-of-range pages.** It checks that a page number above the table is not folded back onto a low entry by dropping the upper bits.
- **Context bank selection.** It checks that switching context really selects another bank.
- **Fault capture.** It checks that a second fault does not overwrite the captured address, and that a fault arriving with the clear is not lost.
- **Back-pressure and ordering.** A stall on the downstream side must hold the output and keep the order. A broken design would drop or reorder the queued access.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;

   // access-type sideband carried with every transfer
   typedef struct packed {
      logic instr;
      logic cache;
      logic burst;
   } acc_attr_t;

   function automatic acc_attr_t mk_attr(input logic instr, input logic cache, input logic burst);
      acc_attr_t a;
      a.instr = instr;
      a.cache = cache;
      a.burst = burst;
      return a;
   endfunction

endpackage

// File: rtl/pxu_table.sv
module pxu_table #(
   parameter int IDX_W = 4,
   parameter int CTX_W = 2,
   parameter int PPN_W = 20
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [CTX_W+IDX_W-1:0] wr_sel,
   input  logic [PPN_W-1:0]       wr_ppn,
   input  logic                   wr_cache,
   input  logic                   wr_allow,
   input  logic [CTX_W+IDX_W-1:0] rd_sel,
   output logic [PPN_W-1:0]       rd_ppn,
   output logic                   rd_cache,
   output logic                   rd_allow
);
   localparam int SEL_W = CTX_W + IDX_W;
   localparam int ENT_N = 1 << SEL_W;

   logic [PPN_W-1:0] ppn_q [ENT_N];
   logic [ENT_N-1:0] cache_q;
   logic [ENT_N-1:0] allow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < ENT_N; e++) begin
            ppn_q[e] <= '0;
         end
         cache_q <= '0;
         allow_q <= '0;
      end else if (wr_en) begin
         ppn_q[wr_sel]   <= wr_ppn;
         cache_q[wr_sel] <= wr_cache;
         allow_q[wr_sel] <= wr_allow;
      end
   end

   assign rd_ppn   = ppn_q[rd_sel];
   assign rd_cache = cache_q[rd_sel];
   assign rd_allow = allow_q[rd_sel];

endmodule

// File: rtl/pxu_xlate.sv
module pxu_xlate
   import page_xlate_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PA_W   = 32,
   parameter int OFFS_W = 12,
   parameter int IDX_W  = 4,
   parameter int CTX_W  = 2
) (
   input  logic                        en,
   input  logic [CTX_W-1:0]            ctx,
   input  logic [VA_W-1:0]             vaddr,
   input  acc_attr_t                   attr_in,
   output logic [CTX_W+IDX_W-1:0]      tbl_sel,
   input  logic [PA_W-OFFS_W-1:0]      tbl_ppn,
   input  logic                        tbl_cache,
   input  logic                        tbl_allow,
   output logic [PA_W-1:0]             paddr,
   output acc_attr_t                   attr_out,
   output logic                        fault
);
   localparam int VPN_W = VA_W - OFFS_W;

   logic [VPN_W-1:0] vpn;
   logic             in_rng;

   assign vpn     = vaddr[VA_W-1:OFFS_W];
   assign tbl_sel = {ctx, vpn[IDX_W-1:0]};

   // page numbers above the table are out of range unless the table spans them all
   if (VPN_W == IDX_W) begin : g_full_span
      assign in_rng = 1'b1;
   end else begin : g_part_span
      assign in_rng = (vpn[VPN_W-1:IDX_W] == '0);
   end

   always_comb begin
      if (en) begin
         paddr          = {tbl_ppn, vaddr[OFFS_W-1:0]};
         attr_out       = attr_in;
         attr_out.cache = tbl_cache;
         fault          = !in_rng || !tbl_allow;
      end else begin
         paddr    = PA_W'(vaddr);
         attr_out = attr_in;
         fault    = 1'b0;
      end
   end

endmodule

// File: rtl/pxu_fault_cap.sv
module pxu_fault_cap #(
   parameter int VA_W  = 32,
   parameter int CTX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic [VA_W-1:0]  vaddr,
   input  logic [CTX_W-1:0] ctx,
   input  logic             clr,
   output logic             irq,
   output logic [VA_W-1:0]  vaddr_q,
   output logic [CTX_W-1:0] ctx_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq     <= 1'b0;
         vaddr_q <= '0;
         ctx_q   <= '0;
      end else begin
         if (clr) begin
            irq <= 1'b0;
         end
         if (hit) begin
            irq <= 1'b1;
            if (!irq || clr) begin
               vaddr_q <= vaddr;
               ctx_q   <= ctx;
            end
         end
      end
   end

endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
   import page_xlate_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PA_W   = 32,
   parameter int OFFS_W = 12,
   parameter int IDX_W  = 4,
   parameter int CTX_W  = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic                        cfg_ctrl,
   input  logic [CTX_W+IDX_W-1:0]      cfg_sel,
   input  logic [PA_W-OFFS_W-1:0]      cfg_ppn,
   input  logic                        cfg_cache,
   input  logic                        cfg_allow,
   input  logic                        cfg_en,
   input  logic [CTX_W-1:0]            cfg_ctx,
   input  logic                        up_valid,
   output logic                        up_ready,
   input  logic [VA_W-1:0]             up_vaddr,
   input  logic                        up_instr,
   input  logic                        up_cache,
   input  logic                        up_burst,
   output logic                        dn_valid,
   input  logic                        dn_ready,
   output logic [PA_W-1:0]             dn_paddr,
   output logic                        dn_instr,
   output logic                        dn_cache,
   output logic                        dn_burst,
   output logic                        fault_irq,
   output logic [VA_W-1:0]             fault_vaddr,
   output logic [CTX_W-1:0]            fault_ctx,
   input  logic                        fault_clr
);
   localparam int PPN_W = PA_W - OFFS_W;
   localparam int SEL_W = CTX_W + IDX_W;

   if (OFFS_W < 1 || OFFS_W >= VA_W || OFFS_W >= PA_W) begin : g_bad_offs
      $error("page_xlate_unit: OFFS_W must be below both address widths");
   end
   if (IDX_W < 1 || IDX_W > VA_W - OFFS_W) begin : g_bad_idx
      $error("page_xlate_unit: IDX_W must fit in the virtual page number");
   end
   if (CTX_W < 1) begin : g_bad_ctx
      $error("page_xlate_unit: CTX_W must be at least 1");
   end

   logic              xl_en_q;
   logic [CTX_W-1:0]  ctx_q;
   logic [SEL_W-1:0]  rd_sel;
   logic [PPN_W-1:0]  rd_ppn;
   logic              rd_cache;
   logic              rd_allow;
   logic [PA_W-1:0]   x_paddr;
   acc_attr_t         x_attr;
   logic              x_fault;
   logic              acc;
   logic              dv_q;
   logic [PA_W-1:0]   pa_q;
   acc_attr_t         attr_q;

   // control register: enable and active context
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xl_en_q <= 1'b0;
         ctx_q   <= '0;
      end else if (cfg_we && cfg_ctrl) begin
         xl_en_q <= cfg_en;
         ctx_q   <= cfg_ctx;
      end
   end

   pxu_table #(.IDX_W(IDX_W), .CTX_W(CTX_W), .PPN_W(PPN_W)) tbl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we && !cfg_ctrl),
      .wr_sel   (cfg_sel),
      .wr_ppn   (cfg_ppn),
      .wr_cache (cfg_cache),
      .wr_allow (cfg_allow),
      .rd_sel   (rd_sel),
      .rd_ppn   (rd_ppn),
      .rd_cache (rd_cache),
      .rd_allow (rd_allow)
   );

   pxu_xlate #(.VA_W(VA_W), .PA_W(PA_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W), .CTX_W(CTX_W)) xl_i (
      .en        (xl_en_q),
      .ctx       (ctx_q),
      .vaddr     (up_vaddr),
      .attr_in   (mk_attr(up_instr, up_cache, up_burst)),
      .tbl_sel   (rd_sel),
      .tbl_ppn   (rd_ppn),
      .tbl_cache (rd_cache),
      .tbl_allow (rd_allow),
      .paddr     (x_paddr),
      .attr_out  (x_attr),
      .fault     (x_fault)
   );

   assign up_ready = !dv_q || dn_ready;
   assign acc      = up_valid && up_ready;

   // single output stage: only permitted accesses are issued
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dv_q   <= 1'b0;
         pa_q   <= '0;
         attr_q <= '0;
      end else if (acc) begin
         dv_q <= !x_fault;
         if (!x_fault) begin
            pa_q   <= x_paddr;
            attr_q <= x_attr;
         end
      end else if (dn_ready) begin
         dv_q <= 1'b0;
      end
   end

   pxu_fault_cap #(.VA_W(VA_W), .CTX_W(CTX_W)) flt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (acc && x_fault),
      .vaddr   (up_vaddr),
      .ctx     (ctx_q),
      .clr     (fault_clr),
      .irq     (fault_irq),
      .vaddr_q (fault_vaddr),
      .ctx_q   (fault_ctx)
   );

   assign dn_valid = dv_q;
   assign dn_paddr = pa_q;
   assign dn_instr = attr_q.instr;
   assign dn_cache = attr_q.cache;
   assign dn_burst = attr_q.burst;

endmodule

// File: rtl/pxu_chk.sv
module pxu_chk #(
   parameter int VA_W   = 32,
   parameter int PA_W   = 32,
   parameter int OFFS_W = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            up_valid,
   input logic            up_ready,
   input logic [VA_W-1:0] up_vaddr,
   input logic            up_instr,
   input logic            up_cache,
   input logic            up_burst,
   input logic            dn_valid,
   input logic            dn_ready,
   input logic [PA_W-1:0] dn_paddr,
   input logic            dn_instr,
   input logic            dn_cache,
   input logic            dn_burst,
   input logic            fault_irq,
   input logic [VA_W-1:0] fault_vaddr,
   input logic            fault_clr,
   input logic            xl_en_q
);
   // R1
   offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_ready) |=> (!dn_valid || dn_paddr[OFFS_W-1:0] == $past(up_vaddr[OFFS_W-1:0])));

   // R3
   sideband_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_ready) |=> (!dn_valid || (dn_instr == $past(up_instr) && dn_burst == $past(up_burst))));

   // R4
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_ready && !xl_en_q) |=>
         (dn_valid && dn_paddr == PA_W'($past(up_vaddr)) && dn_cache == $past(up_cache)));

   // R9
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_irq && !fault_clr) |=> (fault_irq && $stable(fault_vaddr)));

   // R10
   fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_clr && !(up_valid && up_ready)) |=> !fault_irq);

   // R5
   fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_irq) |-> $past(up_valid && up_ready));

   // R11
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_paddr) && $stable(dn_cache)));

   // R11
   ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_ready == (!dn_valid || dn_ready));

   // R12
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!dn_valid && !fault_irq));

endmodule

bind page_xlate_unit pxu_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFFS_W(OFFS_W)) chk_i (.*);

// File: tb/page_xlate_unit_tb_top.sv
module page_xlate_unit_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 0, cfg_ctrl = 0, cfg_cache = 0, cfg_allow = 0, cfg_en = 0;
   logic [5:0]  cfg_sel = '0;
   logic [19:0] cfg_ppn = '0;
   logic [1:0]  cfg_ctx = '0;
   logic        up_valid = 0, up_instr = 0, up_cache = 0, up_burst = 0;
   logic [31:0] up_vaddr = '0;
   logic        up_ready;
   logic        dn_valid, dn_instr, dn_cache, dn_burst;
   logic        dn_ready = 1'b1;
   logic [31:0] dn_paddr;
   logic        fault_irq;
   logic [31:0] fault_vaddr;
   logic [1:0]  fault_ctx;
   logic        fault_clr = 1'b0;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   page_xlate_unit dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_ctrl(cfg_ctrl), .cfg_sel(cfg_sel), .cfg_ppn(cfg_ppn),
      .cfg_cache(cfg_cache), .cfg_allow(cfg_allow), .cfg_en(cfg_en), .cfg_ctx(cfg_ctx),
      .up_valid(up_valid), .up_ready(up_ready), .up_vaddr(up_vaddr),
      .up_instr(up_instr), .up_cache(up_cache), .up_burst(up_burst),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_paddr(dn_paddr),
      .dn_instr(dn_instr), .dn_cache(dn_cache), .dn_burst(dn_burst),
      .fault_irq(fault_irq), .fault_vaddr(fault_vaddr), .fault_ctx(fault_ctx),
      .fault_clr(fault_clr)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr_entry(input logic [1:0] c, input logic [3:0] pg, input logic [19:0] ppn,
                           input logic ca, input logic al);
      @(negedge clk);
      cfg_we = 1; cfg_ctrl = 0; cfg_sel = {c, pg}; cfg_ppn = ppn; cfg_cache = ca; cfg_allow = al;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic wr_ctrl(input logic en, input logic [1:0] c);
      @(negedge clk);
      cfg_we = 1; cfg_ctrl = 1; cfg_en = en; cfg_ctx = c;
      @(negedge clk);
      cfg_we = 0; cfg_ctrl = 0;
   endtask

   // one access; outputs are sampled at the negedge after the accepting edge
   task automatic send(input logic [31:0] va, input logic i, input logic c, input logic b);
      @(negedge clk);
      up_valid = 1; up_vaddr = va; up_instr = i; up_cache = c; up_burst = b;
      @(negedge clk);
      up_valid = 0;
   endtask

   task automatic clear_fault();
      @(negedge clk);
      fault_clr = 1;
      @(negedge clk);
      fault_clr = 0;
   endtask

   task automatic t_reset();
      chk("R12", "dn_valid after reset", 64'(dn_valid), 64'd0);
      chk("R12", "fault_irq after reset", 64'(fault_irq), 64'd0);
      chk("R11", "up_ready idle", 64'(up_ready), 64'd1);
      // disabled by default: passthrough
      send(32'h0000_3ABC, 0, 1, 0);
      chk("R12", "disabled at reset paddr", 64'(dn_paddr), 64'h0000_3ABC);
      // enable without writing entries: every page is protected
      wr_ctrl(1, 0);
      send(32'h0000_1004, 0, 0, 0);
      chk("R12", "unwritten entry faults", 64'(fault_irq), 64'd1);
      chk("R12", "unwritten entry not issued", 64'(dn_valid), 64'd0);
      chk("R12", "context 0 after reset", 64'(fault_ctx), 64'd0);
      clear_fault();
      chk("R10", "clear drops irq", 64'(fault_irq), 64'd0);
   endtask

   task automatic t_bypass();
      wr_ctrl(0, 0);
      send(32'hDEAD_B123, 1, 1, 1);
      chk("R4", "bypass paddr", 64'(dn_paddr), 64'hDEAD_B123);
      chk("R4", "bypass cache", 64'(dn_cache), 64'd1);
      chk("R3", "bypass instr", 64'(dn_instr), 64'd1);
      chk("R3", "bypass burst", 64'(dn_burst), 64'd1);
      chk("R4", "bypass no fault", 64'(fault_irq), 64'd0);
      send(32'h0001_0000, 0, 0, 0);
      chk("R4", "bypass high page valid", 64'(dn_valid), 64'd1);
      chk("R4", "bypass high page cache", 64'(dn_cache), 64'd0);
   endtask

   task automatic t_map();
      wr_entry(0, 3, 20'h12345, 1, 1);
      wr_entry(0, 5, 20'h00005, 0, 1);
      wr_ctrl(1, 0);
      chk("R13", "ctrl write leaves no fault", 64'(fault_irq), 64'd0);
      send(32'h0000_3ABC, 0, 0, 1);
      chk("R1", "mapped paddr", 64'(dn_paddr), 64'h1234_5ABC);
      chk("R2", "cache from entry", 64'(dn_cache), 64'd1);
      chk("R3", "instr carried", 64'(dn_instr), 64'd0);
      chk("R3", "burst carried", 64'(dn_burst), 64'd1);
      send(32'h0000_5FF0, 1, 1, 0);
      chk("R2", "identity paddr", 64'(dn_paddr), 64'h0000_5FF0);
      chk("R2", "device page uncached", 64'(dn_cache), 64'd0);
      chk("R3", "instr carried 1", 64'(dn_instr), 64'd1);
   endtask

   task automatic t_protect();
      wr_entry(0, 7, 20'h0BEEF, 1, 0);
      send(32'h0000_7123, 0, 1, 0);
      chk("R5", "protected not issued", 64'(dn_valid), 64'd0);
      chk("R5", "protected faults", 64'(fault_irq), 64'd1);
      chk("R9", "fault vaddr", 64'(fault_vaddr), 64'h0000_7123);
      chk("R9", "fault ctx", 64'(fault_ctx), 64'd0);
      send(32'h0002_0456, 0, 0, 0);
      chk("R9", "second fault keeps vaddr", 64'(fault_vaddr), 64'h0000_7123);
      chk("R9", "irq held", 64'(fault_irq), 64'd1);
      clear_fault();
      chk("R10", "irq cleared", 64'(fault_irq), 64'd0);
      // page 16 aliases page 0 if upper bits are dropped; entry 0 stays protected, so use page 19 vs 3
      send(32'h0001_3ABC, 0, 0, 0);
      chk("R6", "out of range faults", 64'(fault_irq), 64'd1);
      chk("R6", "out of range not issued", 64'(dn_valid), 64'd0);
      chk("R6", "out of range vaddr", 64'(fault_vaddr), 64'h0001_3ABC);
      clear_fault();
   endtask

   task automatic t_ctx();
      wr_entry(2, 3, 20'h00ABC, 0, 1);
      wr_ctrl(1, 2);
      send(32'h0000_3ABC, 0, 1, 0);
      chk("R7", "ctx2 paddr", 64'(dn_paddr), 64'h00AB_CABC);
      chk("R7", "ctx2 cache", 64'(dn_cache), 64'd0);
      send(32'h0000_9000, 0, 0, 0);
      chk("R13", "fault records ctx2", 64'(fault_ctx), 64'd2);
      clear_fault();
      wr_ctrl(1, 0);
      send(32'h0000_3ABC, 0, 0, 0);
      chk("R7", "back to ctx0", 64'(dn_paddr), 64'h1234_5ABC);
   endtask

   task automatic t_rewrite();
      wr_entry(0, 3, 20'h55555, 0, 1);
      send(32'h0000_3ABC, 0, 1, 0);
      chk("R8", "rewritten paddr", 64'(dn_paddr), 64'h5555_5ABC);
      chk("R8", "rewritten cache", 64'(dn_cache), 64'd0);
   endtask

   task automatic t_clr_same();
      send(32'h0000_7001, 0, 0, 0);
      chk("R10", "pending before", 64'(fault_irq), 64'd1);
      @(negedge clk);
      fault_clr = 1; up_valid = 1; up_vaddr = 32'h0000_7002;
      @(negedge clk);
      fault_clr = 0; up_valid = 0;
      chk("R10", "same-cycle fault keeps irq", 64'(fault_irq), 64'd1);
      chk("R10", "same-cycle fault captured", 64'(fault_vaddr), 64'h0000_7002);
      clear_fault();
   endtask

   task automatic t_stall();
      @(negedge clk);
      dn_ready = 0;
      up_valid = 1; up_vaddr = 32'h0000_3001;
      @(negedge clk);
      up_vaddr = 32'h0000_5002;
      chk("R11", "first out valid", 64'(dn_valid), 64'd1);
      chk("R11", "first paddr", 64'(dn_paddr), 64'h5555_5001);
      chk("R11", "ready low in stall", 64'(up_ready), 64'd0);
      @(negedge clk);
      chk("R11", "held in stall", 64'(dn_paddr), 64'h5555_5001);
      dn_ready = 1;
      @(negedge clk);
      up_valid = 0;
      chk("R11", "second follows", 64'(dn_paddr), 64'h0000_5002);
      chk("R11", "second valid", 64'(dn_valid), 64'd1);
      @(negedge clk);
      chk("R11", "drained", 64'(dn_valid), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_bypass();
      t_map();
      t_protect();
      t_ctx();
      t_rewrite();
      t_clr_same();
      t_stall();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule